// File: doc/BRIEF.md
# Column-compressed 8x8 unsigned multiplier

This block forms the 16-bit unsigned product of two 8-bit operands. Every AND-gate partial-product bit is placed in the column of its weight. Bit a[i]&b[j] goes to column i+j, so the column heights rise from one to eight and fall back to one. Each column passes through one 7:2 compressor cell, which takes the first seven of its bits, and then through one 4:2 compressor cell. Together these leave two 16-bit rows, and a ripple carry-propagate adder adds the two rows to give the product.

The datapath is combinational. A parameter places an optional output register after the adder. When the register is present, it loads on each rising edge while the clock enable is high. It is cleared by an asynchronous active-low reset whose release passes through a two-stage synchronizer. The block is meant to be used as a general or constant-coefficient multiplier inside a transform datapath.

Top module: `vcm_mult8`

## Requirements
- R1: For every unsigned pair op_a, op_b in 0..255, the value that reaches prod equals op_a*op_b taken as a 16-bit unsigned number.
- R2: With the output register present (the default), prod shows the product of the operands sampled at the previous rising edge at which ce was high. Without the register, prod follows the operands combinationally.
- R3: A rising edge with ce low leaves prod unchanged, whatever the operands do.
- R4: rst_n low clears prod to zero at once, without waiting for a clock edge. After rst_n rises, prod stays zero through the next two rising edges, and the third rising edge loads a product.
- R5: The compressor stages leave exactly two rows whose full integer sum equals op_a*op_b. No compressor cell sends a carry past bit 15.
- R6: Extreme operands give exact results: 255 x 255 gives 16'hFE01, a zero operand gives zero, and an operand of one returns the other operand unchanged.
- R7: Each partial-product bit carries weight i+j. With op_a = 2^i and op_b = 2^j, prod has exactly bit i+j set, for all 64 pairs (i, j).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register and the reset synchronizer |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized |
| ce | input | 1 | Load enable of the output register |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| prod | output | 16 | Unsigned product |

## Verification
On every clock the assertions check four things:
- the two rows left by the compressors add up to the true product, and no carry leaves column 15;
- the registered output matches the operands of the previous enabled edge;
- prod holds when ce is low;
- prod stays zero while the synchronized reset is active.

Only the bench scenarios can show that:
- the two-edge release timing of the reset is right;
- the asynchronous clear acts between clock edges;
- all 65536 operand pairs are covered;
- the single-bit weight sweep is correct.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  localparam int OPW    = 8;          // operand width
  localparam int PRW    = 2 * OPW;    // product width, also the column count
  localparam int C72_IN = 7;          // column bits taken by the 7:2 cell
  localparam int SYNC_N = 2;          // reset release synchronizer depth

  typedef logic [PRW-1:0] row_t;
  typedef logic [PRW-1:0][OPW-1:0] colset_t;
endpackage

// File: rtl/vcm_fa.sv
module vcm_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & (a_i ^ b_i));
endmodule

// File: rtl/vcm_cmp42.sv
// Four bits plus a lateral carry-in become a sum and two weight-2 outputs.
// The lateral carry-out does not depend on ci_i, so carries do not ripple.
module vcm_cmp42 (
  input  logic [3:0] x_i,
  input  logic       ci_i,
  output logic       s_o,
  output logic       cy_o,
  output logic       co_o
);
  logic t0;

  vcm_fa u_fa0 (.a_i(x_i[0]), .b_i(x_i[1]), .c_i(x_i[2]), .s_o(t0),  .co_o(co_o));
  vcm_fa u_fa1 (.a_i(t0),     .b_i(x_i[3]), .c_i(ci_i),   .s_o(s_o), .co_o(cy_o));
endmodule

// File: rtl/vcm_cmp72.sv
// Seven bits plus four lateral carry-ins become a sum, one carry and four
// lateral carry-outs.
// co_o[2:0] use only x_i. co_o[3] uses ci_i[1:0], and those come from the
// cin-free outputs of the column below, so no carry chain forms.
module vcm_cmp72 (
  input  logic [6:0] x_i,
  input  logic [3:0] ci_i,
  output logic       s_o,
  output logic       cy_o,
  output logic [3:0] co_o
);
  logic t0, t1, t2, t3;

  vcm_fa u_fa0 (.a_i(x_i[0]), .b_i(x_i[1]),  .c_i(x_i[2]),  .s_o(t0),  .co_o(co_o[0]));
  vcm_fa u_fa1 (.a_i(x_i[3]), .b_i(x_i[4]),  .c_i(x_i[5]),  .s_o(t1),  .co_o(co_o[1]));
  vcm_fa u_fa2 (.a_i(t0),     .b_i(t1),      .c_i(x_i[6]),  .s_o(t2),  .co_o(co_o[2]));
  vcm_fa u_fa3 (.a_i(t2),     .b_i(ci_i[0]), .c_i(ci_i[1]), .s_o(t3),  .co_o(co_o[3]));
  vcm_fa u_fa4 (.a_i(t3),     .b_i(ci_i[2]), .c_i(ci_i[3]), .s_o(s_o), .co_o(cy_o));
endmodule

// File: rtl/vcm_ppgen.sv
// Places each AND term a[i]&b[j] in column i+j, in slot j of that column.
module vcm_ppgen
  import vcm_pkg::*;
(
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  output colset_t        col_o
);
  for (genvar k = 0; k < PRW; k++) begin : g_col
    for (genvar j = 0; j < OPW; j++) begin : g_slot
      if ((k - j >= 0) && (k - j < OPW)) begin : g_and
        assign col_o[k][j] = a_i[k-j] & b_i[j];
      end else begin : g_nil
        assign col_o[k][j] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/vcm_reduce.sv
// Each column: one 7:2 cell takes slots 0..6. One 4:2 cell then merges
// the 7:2 sum, the 7:2 carry from the column below, and slot 7.
module vcm_reduce
  import vcm_pkg::*;
(
  input  colset_t col_i,
  output row_t    row_s_o,
  output row_t    row_c_o,
  output logic    spill_o
);
  row_t s72, c72, s42, cy42, co42;
  logic [PRW-1:0][3:0] co72;

  for (genvar k = 0; k < PRW; k++) begin : g_col
    logic [3:0] ci72;
    logic       c_below;
    logic       ci42;

    if (k == 0) begin : g_base
      assign ci72    = '0;
      assign c_below = 1'b0;
      assign ci42    = 1'b0;
    end else begin : g_link
      assign ci72    = co72[k-1];
      assign c_below = c72[k-1];
      assign ci42    = co42[k-1];
    end

    vcm_cmp72 u_c72 (
      .x_i  (col_i[k][C72_IN-1:0]),
      .ci_i (ci72),
      .s_o  (s72[k]),
      .cy_o (c72[k]),
      .co_o (co72[k])
    );

    vcm_cmp42 u_c42 (
      .x_i  ({1'b0, col_i[k][OPW-1], c_below, s72[k]}),
      .ci_i (ci42),
      .s_o  (s42[k]),
      .cy_o (cy42[k]),
      .co_o (co42[k])
    );
  end

  assign row_s_o = s42;
  assign row_c_o = {cy42[PRW-2:0], 1'b0};
  // Anything leaving column PRW-1 would weigh 2^PRW.
  assign spill_o = c72[PRW-1] | (|co72[PRW-1]) | cy42[PRW-1] | co42[PRW-1];
endmodule

// File: rtl/vcm_cpa.sv
module vcm_cpa
  import vcm_pkg::*;
(
  input  row_t x_i,
  input  row_t y_i,
  output row_t sum_o
);
  logic [PRW-1:0] cr;

  assign cr[0] = 1'b0;
  for (genvar k = 0; k < PRW - 1; k++) begin : g_bit
    vcm_fa u_fa (
      .a_i  (x_i[k]),
      .b_i  (y_i[k]),
      .c_i  (cr[k]),
      .s_o  (sum_o[k]),
      .co_o (cr[k+1])
    );
  end
  assign sum_o[PRW-1] = x_i[PRW-1] ^ y_i[PRW-1] ^ cr[PRW-1];
endmodule

// File: rtl/vcm_mult8.sv
module vcm_mult8
  import vcm_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic [PRW-1:0] prod
);
  colset_t cols;
  row_t    row_s, row_c, sum_w;
  logic    spill;
  logic [SYNC_N-1:0] rst_pipe;
  logic    rst_sync_n;

  vcm_ppgen  u_pp  (.a_i(op_a), .b_i(op_b), .col_o(cols));
  vcm_reduce u_red (.col_i(cols), .row_s_o(row_s), .row_c_o(row_c), .spill_o(spill));
  vcm_cpa    u_cpa (.x_i(row_s), .y_i(row_c), .sum_o(sum_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  if (OUT_REG) begin : g_reg
    row_t prod_d, prod_q;

    always_comb begin
      prod_d = prod_q;
      if (ce) prod_d = sum_w;
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) prod_q <= '0;
      else             prod_q <= prod_d;
    end

    assign prod = prod_q;
  end else begin : g_comb
    assign prod = sum_w;
  end
endmodule

// File: rtl/vcm_mult8_chk.sv
module vcm_mult8_chk
  import vcm_pkg::*;
#(
  parameter bit REG = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rst_sync_n,
  input logic           ce,
  input logic [OPW-1:0] op_a,
  input logic [OPW-1:0] op_b,
  input logic [PRW-1:0] prod,
  input logic [PRW-1:0] row_s,
  input logic [PRW-1:0] row_c,
  input logic           spill
);
  logic [PRW:0] full_ref;
  assign full_ref = (PRW+1)'(op_a) * (PRW+1)'(op_b);

  AST_TWO_ROW_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ((PRW+1)'(row_s) + (PRW+1)'(row_c)) == full_ref); // R5
  AST_NO_SPILL: assert property (@(posedge clk) disable iff (!rst_n)
    !spill); // R5
  AST_PROD_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    prod <= 16'hFE01); // R6

  if (REG) begin : g_reg_chk
    AST_REG_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && rst_sync_n) |=> (prod == $past(full_ref[PRW-1:0]))); // R2
    AST_CE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce && rst_sync_n) |=> $stable(prod)); // R3
    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_sync_n |-> (prod == '0)); // R4
  end
endmodule

bind vcm_mult8 vcm_mult8_chk #(.REG(OUT_REG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .ce         (ce),
  .op_a       (op_a),
  .op_b       (op_b),
  .prod       (prod),
  .row_s      (row_s),
  .row_c      (row_c),
  .spill      (spill)
);

// File: tb/vcm_mult8_tb_top.sv
module vcm_mult8_tb_top;
  logic        clk;
  logic        rst_n;
  logic        ce;
  logic [7:0]  op_a;
  logic [7:0]  op_b;
  logic [15:0] prod;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  vcm_mult8 dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .ce    (ce),
    .op_a  (op_a),
    .op_b  (op_b),
    .prod  (prod)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  function automatic logic [15:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] acc = '0;
    for (int i = 0; i < 8; i++)
      if (b[i]) acc = acc + ({8'h00, a} << i);
    return acc;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, load at posedge, sample 1 ns after the edge
  task automatic mul_step(input string req, input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    op_a = a; op_b = b; ce = 1'b1;
    @(posedge clk); #1;
    chk(req, prod, ref_mul(a, b));
  endtask

  initial begin
    logic [15:0] held;
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; ce = 1'b1; op_a = 8'hFF; op_b = 8'hFF;
    repeat (3) @(posedge clk);
    #1 chk("R4 in reset", prod, 16'h0000);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk("R4 release edge1", prod, 16'h0000);
    @(posedge clk); #1 chk("R4 release edge2", prod, 16'h0000);
    @(posedge clk); #1 chk("R4 release edge3", prod, 16'hFE01);

    // R6 extremes
    mul_step("R6 ff*ff", 8'hFF, 8'hFF);
    mul_step("R6 zero a", 8'h00, 8'hB7);
    mul_step("R6 zero b", 8'hC3, 8'h00);
    mul_step("R6 one a", 8'h01, 8'h9D);
    mul_step("R6 one b", 8'h6E, 8'h01);
    mul_step("R1 aa*55", 8'hAA, 8'h55);
    mul_step("R1 80*80", 8'h80, 8'h80);

    // R7 single-bit weights
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        op_a = 8'(1 << i); op_b = 8'(1 << j); ce = 1'b1;
        @(posedge clk); #1;
        chk("R7 weight", prod, 16'(1 << (i + j)));
      end

    // R3 hold with ce low
    mul_step("R2 pre-hold", 8'd3, 8'd5);
    held = prod;
    @(negedge clk); ce = 1'b0; op_a = 8'd200; op_b = 8'd200;
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); #1 chk("R3 hold", prod, held);
      @(negedge clk); op_a = op_a + 8'd7;
    end
    mul_step("R2 after hold", 8'd200, 8'd200);

    // R4 asynchronous clear between edges
    @(negedge clk); rst_n = 1'b0;
    #1 chk("R4 async clear", prod, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    mul_step("R4 resume", 8'd17, 8'd13);

    // R2 random pairs
    for (int n = 0; n < 2000; n++)
      mul_step("R2 random", 8'($urandom), 8'($urandom));

    // R1 and R5 over every operand pair
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        mul_step("R1 R5 exhaustive", 8'(a), 8'(b));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule